// File: doc/BRIEF.md
# Loop Requeue Stage

The requeue stage sits in front of a circular instruction FIFO and decides, every cycle, which of two instruction streams may write into it. One stream brings freshly dispatched 25-bit instructions. The other brings instructions that have already executed and are coming back from the FIFO output. The block is a two-state controller. In the Updating state it loads new instructions and throws away the old loop body. In the Circulating state it replays the loop body by feeding every returning instruction back in.

Entry into a loop is a rendezvous. A loop-end marker waits at the new-instruction input and a loop-start marker waits at the recirculation input. When both are present at once, both are consumed together, neither reaches the FIFO, and the block switches to Circulating. An abort strobe from the execute stage returns the block to Updating, but only if the abort's predicate held. The block has one registered output slot, which holds its word until the FIFO takes it.

Top module: `loop_requeue`

## Requirements
- R1: After reset the block is in Updating (`circulating` = 0), `out_valid` = 0 and `loop_entered` = 0.
- R2: In Updating, a valid non-tail word at the enqueue input is accepted when the output slot is empty or being drained (`enq_ready` = 1), and appears on `out_instr` with `out_valid` = 1 one clock later.
- R3: In Updating, a valid recirculated word that is not a head is accepted at once (`rcv_ready` = 1), whatever the output state, and never appears at the output.
- R4: A word is a tail when bits [21:18] equal 1111 and a head when bits [21:18] equal 1110; the other bits do not matter. In Updating, a tail at the enqueue input gets `enq_ready` = 0, and a head at the recirculation input gets `rcv_ready` = 0, unless the other marker is present in the same cycle.
- R5: When a valid tail and a valid head are present in the same Updating cycle, both are accepted in that cycle, even if the output slot is full and stalled. Neither reaches the output. `circulating` becomes 1 on the next clock, and `loop_entered` is high for exactly that one cycle.
- R6: In Circulating, `enq_ready` = 0. Every recirculated word, heads included, is accepted when the output slot has room and appears on the output one clock later.
- R7: An abort with `abort_exec` = 1 and `abort_pred_ok` = 1 in Circulating sets `circulating` to 0 on the next clock. With `abort_pred_ok` = 0, or in Updating, the abort has no effect.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_instr` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New instruction present |
| enq_instr | input | 25 | New instruction word |
| enq_ready | output | 1 | New instruction accepted this cycle |
| rcv_valid | input | 1 | Recirculated instruction present |
| rcv_instr | input | 25 | Recirculated instruction word |
| rcv_ready | output | 1 | Recirculated instruction accepted this cycle |
| out_valid | output | 1 | Output slot holds a word for the FIFO |
| out_instr | output | 25 | Word offered to the FIFO |
| out_ready | input | 1 | FIFO takes the output word |
| abort_exec | input | 1 | An abort instruction executed |
| abort_pred_ok | input | 1 | The executed abort's predicate held |
| circulating | output | 1 | 1 in Circulating, 0 in Updating |
| loop_entered | output | 1 | One-cycle pulse after the rendezvous |

## Verification
On every cycle, the assertions check four things:
- the enqueue input is closed while circulating;
- a stalled output word stays stable;
- a lone tail is held back, and a non-head recirculated word is always drained in Updating;
- a qualified abort leaves Circulating, and the loop-entry pulse coincides with the rise of the state.

Only the bench's scenarios can show the following:
- dropped words never reach the FIFO;
- the markers are swallowed rather than forwarded;
- heads do pass through while circulating;
- a failed-predicate abort changes nothing;
- the rendezvous still completes when the output is stalled.

// File: rtl/loop_requeue_pkg.sv
package loop_requeue_pkg;
  // instruction geometry and marker opcodes (field decoded by neighbours)
  localparam int unsigned INSTR_W = 25;
  localparam int unsigned OP_LO   = 18;
  localparam int unsigned OP_W    = 4;
  localparam logic [OP_W-1:0] OP_HEAD = 4'b1110;
  localparam logic [OP_W-1:0] OP_TAIL = 4'b1111;

  typedef enum logic {
    ST_UPDATING    = 1'b0,
    ST_CIRCULATING = 1'b1
  } rq_state_e;
endpackage

// File: rtl/rq_marker_detect.sv
module rq_marker_detect #(
  parameter int unsigned IW    = 25,
  parameter int unsigned OP_LO = 18,
  parameter int unsigned OP_W  = 4,
  parameter logic [OP_W-1:0] CODE = '1
) (
  input  logic [IW-1:0] instr,
  output logic          hit
);
  localparam int unsigned OP_HI = OP_LO + OP_W - 1;

  function automatic logic code_match(input logic [IW-1:0] w);
    return w[OP_HI:OP_LO] == CODE;
  endfunction

  assign hit = code_match(instr);
endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import loop_requeue_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enq_valid,
  input  logic      enq_is_tail,
  input  logic      rcv_valid,
  input  logic      rcv_is_head,
  input  logic      can_load,
  input  logic      abort_exec,
  input  logic      abort_pred_ok,
  output logic      enq_ready,
  output logic      rcv_ready,
  output logic      push,
  output logic      push_from_rcv,
  output logic      rendezvous,
  output rq_state_e state,
  output logic      entered
);
  rq_state_e state_q, state_d;
  logic      updating;
  logic      abort_hit;

  assign updating   = (state_q == ST_UPDATING);
  assign abort_hit  = abort_exec & abort_pred_ok;
  assign rendezvous = updating & enq_valid & enq_is_tail & rcv_valid & rcv_is_head;

  always_comb begin
    enq_ready     = 1'b0;
    rcv_ready     = 1'b0;
    push          = 1'b0;
    push_from_rcv = 1'b0;
    if (updating) begin
      enq_ready = enq_is_tail ? rendezvous : can_load;
      rcv_ready = rcv_is_head ? rendezvous : 1'b1;
      push      = enq_valid & ~enq_is_tail & can_load;
    end else begin
      rcv_ready     = can_load;
      push          = rcv_valid & can_load;
      push_from_rcv = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    if (updating && rendezvous)   state_d = ST_CIRCULATING;
    else if (!updating && abort_hit) state_d = ST_UPDATING;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_UPDATING;
      entered <= 1'b0;
    end else begin
      state_q <= state_d;
      entered <= rendezvous;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/rq_outreg.sv
module rq_outreg #(
  parameter int unsigned IW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [IW-1:0] out_instr,
  output logic          can_load
);
  assign can_load = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_instr <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_instr <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_requeue.sv
module loop_requeue
  import loop_requeue_pkg::*;
#(
  parameter int unsigned IW = INSTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic [IW-1:0] enq_instr,
  output logic          enq_ready,
  input  logic          rcv_valid,
  input  logic [IW-1:0] rcv_instr,
  output logic          rcv_ready,
  output logic          out_valid,
  output logic [IW-1:0] out_instr,
  input  logic          out_ready,
  input  logic          abort_exec,
  input  logic          abort_pred_ok,
  output logic          circulating,
  output logic          loop_entered
);
  // named internal events, also observed by the checker
  logic      enq_is_tail;
  logic      rcv_is_head;
  logic      can_load;
  logic      push;
  logic      push_from_rcv;
  logic      rendezvous;
  rq_state_e state;
  logic [IW-1:0] push_data;

  rq_marker_detect #(.IW(IW), .OP_LO(OP_LO), .OP_W(OP_W), .CODE(OP_TAIL)) u_tail_det (
    .instr(enq_instr), .hit(enq_is_tail)
  );

  rq_marker_detect #(.IW(IW), .OP_LO(OP_LO), .OP_W(OP_W), .CODE(OP_HEAD)) u_head_det (
    .instr(rcv_instr), .hit(rcv_is_head)
  );

  rq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enq_valid    (enq_valid),
    .enq_is_tail  (enq_is_tail),
    .rcv_valid    (rcv_valid),
    .rcv_is_head  (rcv_is_head),
    .can_load     (can_load),
    .abort_exec   (abort_exec),
    .abort_pred_ok(abort_pred_ok),
    .enq_ready    (enq_ready),
    .rcv_ready    (rcv_ready),
    .push         (push),
    .push_from_rcv(push_from_rcv),
    .rendezvous   (rendezvous),
    .state        (state),
    .entered      (loop_entered)
  );

  assign push_data = push_from_rcv ? rcv_instr : enq_instr;

  rq_outreg #(.IW(IW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (push),
    .din      (push_data),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_instr(out_instr),
    .can_load (can_load)
  );

  assign circulating = (state == ST_CIRCULATING);
endmodule

// File: rtl/loop_requeue_chk.sv
module loop_requeue_chk #(
  parameter int unsigned IW = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic          rcv_valid,
  input logic          rcv_ready,
  input logic          enq_is_tail,
  input logic          rcv_is_head,
  input logic          out_valid,
  input logic [IW-1:0] out_instr,
  input logic          out_ready,
  input logic          abort_exec,
  input logic          abort_pred_ok,
  input logic          circulating,
  input logic          loop_entered
);
  assert_enq_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    circulating |-> !enq_ready);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_instr)));

  assert_tail_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!circulating && enq_valid && enq_is_tail && !(rcv_valid && rcv_is_head)) |-> !enq_ready);

  assert_drop_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!circulating && rcv_valid && !rcv_is_head) |-> rcv_ready);

  assert_abort_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (circulating && abort_exec && abort_pred_ok) |=> !circulating);

  assert_entry_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_entered |-> $rose(circulating));
endmodule

bind loop_requeue loop_requeue_chk #(.IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enq_valid    (enq_valid),
  .enq_ready    (enq_ready),
  .rcv_valid    (rcv_valid),
  .rcv_ready    (rcv_ready),
  .enq_is_tail  (enq_is_tail),
  .rcv_is_head  (rcv_is_head),
  .out_valid    (out_valid),
  .out_instr    (out_instr),
  .out_ready    (out_ready),
  .abort_exec   (abort_exec),
  .abort_pred_ok(abort_pred_ok),
  .circulating  (circulating),
  .loop_entered (loop_entered)
);

// File: tb/test_loop_requeue.sv
module test_loop_requeue;
  localparam int IW = 25;
  localparam logic [IW-1:0] I_A   = 25'h0000123;
  localparam logic [IW-1:0] I_B   = 25'h1C00055;
  localparam logic [IW-1:0] I_C   = 25'h0040ABC;
  localparam logic [IW-1:0] I_D   = 25'h0080001;
  localparam logic [IW-1:0] I_E   = 25'h0100F0F;
  localparam logic [IW-1:0] HEAD  = 25'h0380000;
  localparam logic [IW-1:0] TAIL  = 25'h03C0000;
  localparam logic [IW-1:0] TAILX = 25'h1FC0000;
  localparam logic [IW-1:0] NONE  = 25'h0000000;
  localparam int VW = 3*IW + 10;
  localparam int NV = 13;

  // {ev, ei, rv, ri, ordy, abx, abp, x_er, x_rr, x_ov, x_oi, x_circ, x_ent}
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b1, I_A,   1'b0, NONE, 3'b000, 2'b11, 1'b1, I_A,  2'b00},
    {1'b1, I_B,   1'b0, NONE, 3'b000, 2'b01, 1'b1, I_A,  2'b00},
    {1'b1, I_B,   1'b0, NONE, 3'b100, 2'b11, 1'b1, I_B,  2'b00},
    {1'b1, TAIL,  1'b0, NONE, 3'b100, 2'b01, 1'b0, NONE, 2'b00},
    {1'b1, TAIL,  1'b1, I_C,  3'b100, 2'b01, 1'b0, NONE, 2'b00},
    {1'b0, NONE,  1'b1, HEAD, 3'b100, 2'b10, 1'b0, NONE, 2'b00},
    {1'b1, TAILX, 1'b1, HEAD, 3'b100, 2'b11, 1'b0, NONE, 2'b11},
    {1'b1, I_D,   1'b1, I_E,  3'b100, 2'b01, 1'b1, I_E,  2'b10},
    {1'b0, NONE,  1'b1, HEAD, 3'b100, 2'b01, 1'b1, HEAD, 2'b10},
    {1'b0, NONE,  1'b1, I_E,  3'b000, 2'b00, 1'b1, HEAD, 2'b10},
    {1'b0, NONE,  1'b1, I_E,  3'b110, 2'b01, 1'b1, I_E,  2'b10},
    {1'b0, NONE,  1'b0, NONE, 3'b111, 2'b01, 1'b0, NONE, 2'b00},
    {1'b1, I_A,   1'b0, NONE, 3'b100, 2'b11, 1'b1, I_A,  2'b00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0, rcv_valid = 1'b0, out_ready = 1'b0;
  logic          abort_exec = 1'b0, abort_pred_ok = 1'b0;
  logic [IW-1:0] enq_instr = '0, rcv_instr = '0;
  logic          enq_ready, rcv_ready, out_valid, circulating, loop_entered;
  logic [IW-1:0] out_instr;
  int checks = 0;
  int errors = 0;
  logic er_s, rr_s;

  always #2 clk = ~clk;

  loop_requeue i_loop_requeue (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_instr(enq_instr), .enq_ready(enq_ready),
    .rcv_valid(rcv_valid), .rcv_instr(rcv_instr), .rcv_ready(rcv_ready),
    .out_valid(out_valid), .out_instr(out_instr), .out_ready(out_ready),
    .abort_exec(abort_exec), .abort_pred_ok(abort_pred_ok),
    .circulating(circulating), .loop_entered(loop_entered)
  );

  task automatic check(input string tag, input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive after negedge, sample readies before the edge, outputs after it
  task automatic step(input logic ev, input logic [IW-1:0] ei, input logic rv,
                      input logic [IW-1:0] ri, input logic ordy, input logic ax,
                      input logic ap);
    @(negedge clk);
    enq_valid = ev; enq_instr = ei; rcv_valid = rv; rcv_instr = ri;
    out_ready = ordy; abort_exec = ax; abort_pred_ok = ap;
    #1;
    er_s = enq_ready; rr_s = rcv_ready;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 circulating after reset", IW'(circulating), '0);
    check("R1 out_valid after reset", IW'(out_valid), '0);
    check("R1 loop_entered after reset", IW'(loop_entered), '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VECS[k];
      step(v[VW-1], v[VW-2 -: IW], v[VW-IW-2], v[VW-IW-3 -: IW],
           v[IW+7], v[IW+6], v[IW+5]);
      check($sformatf("R2/R4/R6 enq_ready vec %0d", k), IW'(er_s), IW'(v[IW+4]));
      check($sformatf("R3/R4/R6 rcv_ready vec %0d", k), IW'(rr_s), IW'(v[IW+3]));
      check($sformatf("R2/R6/R8 out_valid vec %0d", k), IW'(out_valid), IW'(v[IW+2]));
      if (v[IW+2])
        check($sformatf("R2/R6/R8 out_instr vec %0d", k), out_instr, v[IW+1 -: IW]);
      check($sformatf("R5/R7 circulating vec %0d", k), IW'(circulating), IW'(v[1]));
      check($sformatf("R5 loop_entered vec %0d", k), IW'(loop_entered), IW'(v[0]));
    end

    // R5: rendezvous completes while the output word (A) is stalled
    step(1'b1, TAIL, 1'b1, HEAD, 1'b0, 1'b0, 1'b0);
    check("R5 enq_ready with stalled output", IW'(er_s), 1);
    check("R5 rcv_ready with stalled output", IW'(rr_s), 1);
    check("R5 circulating after stalled rendezvous", IW'(circulating), 1);
    check("R8 out_instr held during rendezvous", out_instr, I_A);
    check("R5 loop_entered pulse", IW'(loop_entered), 1);
    step(1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0);
    check("R5 loop_entered one cycle only", IW'(loop_entered), 0);
    check("R8 out_valid held", IW'(out_valid), 1);

    // R7: qualified abort exits, then abort in Updating has no effect
    step(1'b0, NONE, 1'b0, NONE, 1'b1, 1'b1, 1'b1);
    check("R7 abort exits circulating", IW'(circulating), 0);
    step(1'b0, NONE, 1'b0, NONE, 1'b1, 1'b1, 1'b1);
    check("R7 abort in Updating keeps Updating", IW'(circulating), 0);
    check("R7 abort in Updating leaves output empty", IW'(out_valid), 0);

    // R1: reset from Circulating
    step(1'b1, TAIL, 1'b1, HEAD, 1'b1, 1'b0, 1'b0);
    check("R5 re-entry", IW'(circulating), 1);
    step(1'b0, NONE, 1'b1, I_C, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0; rcv_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 circulating after mid-loop reset", IW'(circulating), 0);
    check("R1 out_valid after mid-loop reset", IW'(out_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule